// File: doc/BRIEF.md
# Windowed Command and Interrupt Status Controller

This block is the host-facing control core of a network adapter. The host writes a 16-bit command word through a simple synchronous register port. The top five bits of the word pick an operation and the low eleven bits carry its operand. The block keeps the currently selected register window, the enable states of the receiver and the transmitter, an interrupt mask and eight latched status bits. It presents all of this as one 16-bit status word that the host can read at any time.

The transmit and receive datapaths report events as one-cycle pulses, and each pulse sets a sticky status bit. The host clears these bits with an acknowledge command whose low operand byte selects the bits to clear. The interrupt output is high while an enabled status bit is pending. Reset commands for the whole block, the receive path or the transmit path keep a busy flag raised for a parameterised number of cycles. The host polls that flag, and any command written while it is high is dropped.

Top module: `host_cmd_ctrl`

## Requirements
- R1: A command word carries its opcode in bits 15:11 and its operand in bits 10:0. Operand bits that an opcode does not use have no effect.
- R2: Opcode 1 sets the window to operand bits 2:0. Status bits 15:13 show the window one cycle after the write.
- R3: Opcodes 0, 5 and 11 raise status bit 12 for BUSY_CYCLES cycles, starting the cycle after the write. Any command written while bit 12 is set is ignored.
- R4: A pulse on evtIn bit k (k = 1, 2, 3, 4, 5 or 7) sets status bit k, and the bit stays set. Pulses on evtIn bits 0 and 6 have no effect. The bit names are 1 adapter failure, 2 TX complete, 3 TX available, 4 RX complete, 5 RX early, 6 interrupt requested and 7 update statistics.
- R5: Opcode 13 (word 0x6800 | bits) clears every status bit whose operand bit 7:0 is set. An event pulse on the same bit in the same cycle wins over the clear.
- R6: Opcode 12 sets status bit 6. Opcode 14 loads the interrupt mask from operand bits 7:0.
- R7: irqOut is high while any status bit among 7:1 is set and its mask bit is set. Status bit 0 becomes set the cycle after irqOut is high and stays set until it is acknowledged while irqOut is low.
- R8: Opcodes 4 and 3 enable and disable the receiver. Opcodes 9 and 10 enable and disable the transmitter. Both start disabled.
- R9: Opcode 0 clears the window, the mask, all status bits and both enables. Opcode 5 disables the receiver and clears status bits 4 and 5. Opcode 11 disables the transmitter and clears status bits 2 and 3. A reset beats an event in the same cycle.
- R10: Opcodes with no defined meaning (2, 6, 7, 8, 15 to 31) complete at once with no effect.
- R11: After the reset pin, the status word is 0x0000 and irqOut, rxEnabled and txEnabled are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdWrEn | input | 1 | Command write strobe |
| cmdWord | input | 16 | Command word (opcode 15:11, operand 10:0) |
| evtIn | input | 8 | Event pulses from the datapaths, one bit per status bit |
| statusWord | output | 16 | Window, busy flag and latched status bits |
| irqOut | output | 1 | Interrupt request |
| rxEnabled | output | 1 | Receiver enable state |
| txEnabled | output | 1 | Transmitter enable state |

## Verification
A command or event applied before a clock edge changes the status word, the enables and the mask exactly one edge later, so the checks sample at the falling edge that follows that rising edge. irqOut is combinational on the mask and the latched bits, so it moves in that same sample. Status bit 0 trails irqOut by one more edge, and the bench checks it on the following idle cycle. The busy window is measured edge by edge: the flag must be set in the samples after edges 1 to BUSY_CYCLES and clear in the sample after the next edge, and a window write made inside that interval must leave no trace.

// File: rtl/hcc_pkg.sv
package hcc_pkg;

  localparam int CMD_W    = 16;
  localparam int OP_W     = 5;
  localparam int ARG_W    = CMD_W - OP_W;
  localparam int STAT_BITS = 8;
  localparam int WIN_W    = 3;

  // Which status bits the event inputs may set, and which a path reset clears
  localparam logic [STAT_BITS-1:0] EVT_BITS = 8'hBE;
  localparam logic [STAT_BITS-1:0] RX_BITS  = 8'h30;
  localparam logic [STAT_BITS-1:0] TX_BITS  = 8'h0C;
  localparam int REQ_BIT = 6;

  typedef enum logic [OP_W-1:0] {
    OP_FULL_RESET = 5'd0,
    OP_SET_WINDOW = 5'd1,
    OP_RX_OFF     = 5'd3,
    OP_RX_ON      = 5'd4,
    OP_RX_RESET   = 5'd5,
    OP_TX_ON      = 5'd9,
    OP_TX_OFF     = 5'd10,
    OP_TX_RESET   = 5'd11,
    OP_RAISE_IRQ  = 5'd12,
    OP_ACK        = 5'd13,
    OP_LOAD_MASK  = 5'd14
  } opcode_e;

  typedef struct packed {
    logic                 clrAll;
    logic                 clrRx;
    logic                 clrTx;
    logic                 reqIntr;
    logic                 ackEn;
    logic                 maskLoad;
    logic [STAT_BITS-1:0] argByte;
  } strobe_t;

endpackage

// File: rtl/hcc_control.sv
module hcc_control
  import hcc_pkg::*;
#(
  parameter int BUSY_CYCLES = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdWrEn,
  input  logic [CMD_W-1:0] cmdWord,
  output strobe_t          strb,
  output logic [WIN_W-1:0] windowQ,
  output logic             busy,
  output logic             rxEnQ,
  output logic             txEnQ
);

  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

  logic [CNT_W-1:0] busyCntQ;
  logic             accept;
  logic             startBusy;
  opcode_e          opcode;
  logic             unusedArgHi;

  assign busy        = (busyCntQ != '0);
  assign accept      = cmdWrEn && !busy;
  assign opcode      = opcode_e'(cmdWord[CMD_W-1:ARG_W]);
  assign unusedArgHi = ^cmdWord[ARG_W-1:STAT_BITS];

  always_comb begin
    strb         = '0;
    strb.argByte = cmdWord[STAT_BITS-1:0];
    startBusy    = 1'b0;
    if (accept) begin
      case (opcode)
        OP_FULL_RESET: begin strb.clrAll = 1'b1; startBusy = 1'b1; end
        OP_RX_RESET:   begin strb.clrRx  = 1'b1; startBusy = 1'b1; end
        OP_TX_RESET:   begin strb.clrTx  = 1'b1; startBusy = 1'b1; end
        OP_RAISE_IRQ:  strb.reqIntr  = 1'b1;
        OP_ACK:        strb.ackEn    = 1'b1;
        OP_LOAD_MASK:  strb.maskLoad = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      windowQ  <= '0;
      rxEnQ    <= 1'b0;
      txEnQ    <= 1'b0;
      busyCntQ <= '0;
    end else begin
      if (startBusy) begin
        busyCntQ <= CNT_W'(BUSY_CYCLES);
      end else if (busy) begin
        busyCntQ <= busyCntQ - 1'b1;
      end
      if (accept) begin
        case (opcode)
          OP_FULL_RESET: begin windowQ <= '0; rxEnQ <= 1'b0; txEnQ <= 1'b0; end
          OP_SET_WINDOW: windowQ <= cmdWord[WIN_W-1:0];
          OP_RX_OFF, OP_RX_RESET: rxEnQ <= 1'b0;
          OP_RX_ON:      rxEnQ <= 1'b1;
          OP_TX_ON:      txEnQ <= 1'b1;
          OP_TX_OFF, OP_TX_RESET: txEnQ <= 1'b0;
          default: ;
        endcase
      end
    end
  end

  // R3
  busy_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    busyCntQ <= CNT_W'(BUSY_CYCLES));

  // R3
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWrEn && busy) |=> ($stable(windowQ) && $stable(rxEnQ) && $stable(txEnQ)));

  // R3
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrAll || strb.clrRx || strb.clrTx) |=> busy);

endmodule

// File: rtl/hcc_datapath.sv
module hcc_datapath
  import hcc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              strb,
  input  logic [STAT_BITS-1:0] evtIn,
  output logic [STAT_BITS-1:0] latchQ,
  output logic                 irqOut
);

  logic [STAT_BITS-1:0] maskQ;

  assign irqOut = |(latchQ[STAT_BITS-1:1] & maskQ[STAT_BITS-1:1]);

  always_ff @(posedge clk) begin
    if (!rstN || strb.clrAll) begin
      maskQ <= '0;
    end else if (strb.maskLoad) begin
      maskQ <= strb.argByte;
    end
  end

  for (genvar i = 0; i < STAT_BITS; i++) begin : g_bit
    logic setI, clrI, rstI;
    if (i == 0) begin : g_summary
      assign setI = irqOut;
      assign rstI = strb.clrAll;
    end else begin : g_source
      assign setI = (EVT_BITS[i] & evtIn[i]) | ((i == REQ_BIT) & strb.reqIntr);
      assign rstI = strb.clrAll | (RX_BITS[i] & strb.clrRx) | (TX_BITS[i] & strb.clrTx);
    end
    assign clrI = strb.ackEn & strb.argByte[i];

    always_ff @(posedge clk) begin
      if (!rstN || rstI) begin
        latchQ[i] <= 1'b0;
      end else if (setI) begin
        latchQ[i] <= 1'b1;
      end else if (clrI) begin
        latchQ[i] <= 1'b0;
      end
    end

    // R5
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
      (strb.ackEn && strb.argByte[i] && !evtIn[i] && !strb.reqIntr && !irqOut)
        |=> !latchQ[i]);
  end

  // R7
  summary_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut && !strb.clrAll) |=> latchQ[0]);

  // R9
  full_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrAll |=> (latchQ == '0 && !irqOut));

  // R6
  mask_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.maskLoad && !strb.clrAll) |=> (maskQ == $past(strb.argByte)));

endmodule

// File: rtl/host_cmd_ctrl.sv
module host_cmd_ctrl
  import hcc_pkg::*;
#(
  parameter int BUSY_CYCLES = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdWrEn,
  input  logic [15:0] cmdWord,
  input  logic [7:0]  evtIn,
  output logic [15:0] statusWord,
  output logic        irqOut,
  output logic        rxEnabled,
  output logic        txEnabled
);

  localparam int PAD_W = CMD_W - WIN_W - 1 - STAT_BITS;

  strobe_t              strb;
  logic [WIN_W-1:0]     windowQ;
  logic                 busy;
  logic [STAT_BITS-1:0] latchQ;

  hcc_control #(.BUSY_CYCLES(BUSY_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdWrEn(cmdWrEn), .cmdWord(cmdWord),
    .strb(strb), .windowQ(windowQ), .busy(busy),
    .rxEnQ(rxEnabled), .txEnQ(txEnabled)
  );

  hcc_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .evtIn(evtIn),
    .latchQ(latchQ), .irqOut(irqOut)
  );

  assign statusWord = {windowQ, busy, {PAD_W{1'b0}}, latchQ};

endmodule

// File: tb/tb_host_cmd_ctrl.sv
`timescale 1ns/1ps
module tb_host_cmd_ctrl;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdWrEn = 1'b0;
  logic [15:0] cmdWord = '0;
  logic [7:0]  evtIn = '0;
  logic [15:0] statusWord;
  logic        irqOut, rxEnabled, txEnabled;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  host_cmd_ctrl #(.BUSY_CYCLES(4)) dut (
    .clk(clk), .rstN(rstN), .cmdWrEn(cmdWrEn), .cmdWord(cmdWord),
    .evtIn(evtIn), .statusWord(statusWord), .irqOut(irqOut),
    .rxEnabled(rxEnabled), .txEnabled(txEnabled)
  );

  // {valid, cmd, evt, expStatus, expIrq, expRx, expTx}
  localparam int NV = 16;
  localparam logic [43:0] VEC [NV] = '{
    {1'b1, 16'h0803, 8'h00, 16'h6000, 3'b000},  // R2 window 3
    {1'b0, 16'h0000, 8'h04, 16'h6004, 3'b000},  // R4 tx complete
    {1'b1, 16'h7004, 8'h00, 16'h6004, 3'b100},  // R6 mask, R7 irq
    {1'b0, 16'h0000, 8'h00, 16'h6005, 3'b100},  // R7 summary bit
    {1'b1, 16'h6804, 8'h00, 16'h6001, 3'b000},  // R5 ack bit 2
    {1'b1, 16'h6801, 8'h00, 16'h6000, 3'b000},  // R7 ack summary
    {1'b1, 16'h6000, 8'h00, 16'h6040, 3'b000},  // R6 request
    {1'b1, 16'h7040, 8'h00, 16'h6040, 3'b100},  // R6 mask reload
    {1'b1, 16'h6840, 8'h10, 16'h6011, 3'b000},  // R5 ack with event
    {1'b1, 16'h2000, 8'h00, 16'h6011, 3'b010},  // R8 rx on
    {1'b1, 16'h4800, 8'h00, 16'h6011, 3'b011},  // R8 tx on
    {1'b1, 16'hB800, 8'h00, 16'h6011, 3'b011},  // R10 unknown
    {1'b1, 16'h1FFF, 8'h00, 16'h6011, 3'b001},  // R1 operand ignored
    {1'b1, 16'h6811, 8'h00, 16'h6000, 3'b001},  // R5 ack two bits
    {1'b0, 16'h0000, 8'h41, 16'h6000, 3'b001},  // R4 ignored inputs
    {1'b0, 16'h0000, 8'hBE, 16'h60BE, 3'b001}   // R4 all events
  };

  function automatic string reqOf(int idx);
    case (idx)
      0: return "R2";   1: return "R4";   2: return "R6";   3: return "R7";
      4: return "R5";   5: return "R7";   6: return "R6";   7: return "R6";
      8: return "R5";   9: return "R8";   10: return "R8";  11: return "R10";
      12: return "R1";  13: return "R5";  default: return "R4";
    endcase
  endfunction

  task automatic check(string req, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=0x%04h expected=0x%04h", req, what, act, exp);
    end
  endtask

  task automatic checkAll(string req, logic [15:0] st, logic irq, logic rx, logic tx);
    check(req, "status", statusWord, st);
    check(req, "irq", {15'd0, irqOut}, {15'd0, irq});
    check(req, "rx", {15'd0, rxEnabled}, {15'd0, rx});
    check(req, "tx", {15'd0, txEnabled}, {15'd0, tx});
  endtask

  // drive at a falling edge, let one rising edge pass, return at the next falling edge
  task automatic step(logic valid, logic [15:0] cmd, logic [7:0] evt);
    cmdWrEn = valid;
    cmdWord = cmd;
    evtIn   = evt;
    @(posedge clk);
    @(negedge clk);
    cmdWrEn = 1'b0;
    cmdWord = '0;
    evtIn   = '0;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) step(1'b0, 16'h0000, 8'h00);
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    // R11 reset state
    checkAll("R11", 16'h0000, 1'b0, 1'b0, 1'b0);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][43], VEC[i][42:27], VEC[i][26:19]);
      checkAll(reqOf(i), VEC[i][18:3], VEC[i][2], VEC[i][1], VEC[i][0]);
    end

    // R9 tx reset clears bits 2,3 and the transmitter; R3 busy begins
    step(1'b1, 16'h5800, 8'h00);
    checkAll("R9", 16'h70B2, 1'b0, 1'b0, 1'b0);
    // R3 window write while busy is dropped
    step(1'b1, 16'h0805, 8'h00);
    checkAll("R3", 16'h70B2, 1'b0, 1'b0, 1'b0);
    idle(2);
    check("R3", "busy last cycle", statusWord, 16'h70B2);
    idle(1);
    check("R3", "busy released", statusWord, 16'h60B2);

    // R8 then R9 rx reset
    step(1'b1, 16'h2000, 8'h00);
    checkAll("R8", 16'h60B2, 1'b0, 1'b1, 1'b0);
    step(1'b1, 16'h2800, 8'h00);
    checkAll("R9", 16'h7082, 1'b0, 1'b0, 1'b0);
    idle(4);
    check("R3", "rx reset busy end", statusWord, 16'h6082);

    // R7 mask all, summary bit one cycle later
    step(1'b1, 16'h70FF, 8'h00);
    checkAll("R7", 16'h6082, 1'b1, 1'b0, 1'b0);
    step(1'b0, 16'h0000, 8'h00);
    checkAll("R7", 16'h6083, 1'b1, 1'b0, 1'b0);
    // R7 acknowledging bit 0 while irq stays high keeps it set
    step(1'b1, 16'h6801, 8'h00);
    checkAll("R7", 16'h6083, 1'b1, 1'b0, 1'b0);

    // R9 global reset, event in the same cycle loses
    step(1'b1, 16'h2000, 8'h00);
    step(1'b1, 16'h0000, 8'h80);
    checkAll("R9", 16'h1000, 1'b0, 1'b0, 1'b0);
    idle(4);
    checkAll("R9", 16'h0000, 1'b0, 1'b0, 1'b0);
    // R9 mask was cleared: a new event raises no irq
    step(1'b0, 16'h0000, 8'h02);
    checkAll("R9", 16'h0002, 1'b0, 1'b0, 1'b0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule